// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a 16-bit signal processor built around a 32-bit accumulator. Each cycle it may take one operation: a 16-bit operand (or an 8-bit short immediate) is loaded into, added to, subtracted from or compared against the upper half of the accumulator, or merged into it with a bitwise AND, OR or XOR. A modify operation shifts, negates or takes the absolute value of the whole 32-bit accumulator, but only when the selected condition holds. Two factor registers feed a fractional multiplier whose doubled product is always visible.

The condition evaluator looks at the current flags and reports whether a branch or a conditional modify would be taken. The surrounding sequencer fetches operands, owns the program counter and uses `condTrue` for its own branch decisions. All state updates happen on the rising clock edge. `condTrue` is combinational from the stored flags and the condition inputs.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, both factor registers, the product and all flags are zero.
- R2: Operation code 1 (load) writes the operand into accumulator bits 31..16 and keeps bits 15..0. It sets Z when the full 32-bit accumulator is zero and copies bit 31 into N. L and V are left as they were.
- R3: Operation codes 4 (add) and 2 (subtract) combine accumulator bits 31..16 with the operand and keep bits 15..0. Z is set when the 16-bit result is zero and N is result bit 15. L is the carry out of an add or the borrow of a subtract, and V is signed overflow.
- R4: Operation code 3 (compare) sets all four flags exactly as a subtract would, and it leaves the accumulator unchanged.
- R5: Operation codes 5, 6 and 7 (AND, OR, XOR) combine the full accumulator with the operand shifted left by 16. AND therefore clears bits 15..0, and OR and XOR pass them through. Z and N follow the 32-bit result, and L and V are kept.
- R6: When `shortSel` is high, the operand used is `immByte` zero-extended to 16 bits instead of `operand`.
- R7: `condTrue` is 1 for `condSel` 0x0. For 0x5 it is 1 when Z equals `condPol`, and for 0x7 when N equals `condPol`. Every other `condSel` value gives 0.
- R8: Operation code 8 (modify) with `condTrue` high applies `modCode` to the full accumulator: 2 is an arithmetic shift right by one, 3 a shift left by one, 6 a two's-complement negate, and 7 an absolute value (0x80000000 stays 0x80000000). Z and N follow the result, and L and V are kept.
- R9: A modify with `condTrue` low, or with a `modCode` other than 2, 3, 6 or 7, changes neither the accumulator nor the flags.
- R10: Operation codes 9 and 10 load X and Y from the operand. `product` equals the signed product X·Y shifted left by one, modulo 2^32.
- R11: With `opValid` low, or for operation codes 0 and 11 to 15, no register changes.
- R12: `status` carries N at bit 15, V at bit 14, Z at bit 13 and L at bit 12, with bits 11..0 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation select (see requirements) |
| operand | input | 16 | Full-width operand |
| shortSel | input | 1 | Use the zero-extended short immediate |
| immByte | input | 8 | Short immediate value |
| condSel | input | 4 | Condition select |
| condPol | input | 1 | Flag value the condition compares against |
| modCode | input | 3 | Modify function select |
| acc | output | 32 | Accumulator |
| product | output | 32 | Doubled signed product of X and Y |
| status | output | 16 | Status word holding the flags |
| condTrue | output | 1 | Selected condition holds |

## Verification
The bench builds the block with the default 16-bit data width and 8-bit short immediate. That gives a 32-bit accumulator, so every arithmetic boundary can be reached directly: the 0x7FFF/0x8000 overflow points, a borrow from zero, and the single negative value that has no positive counterpart. A directed run drives each of these corners. A long stream of mixed operations then steers the operands toward boundary values, so that conditional modifies are seen both taken and skipped, with flag states produced by earlier arithmetic.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  // Operation codes presented on opCode
  localparam logic [3:0] OPC_LOAD = 4'd1;
  localparam logic [3:0] OPC_SUB  = 4'd2;
  localparam logic [3:0] OPC_CMP  = 4'd3;
  localparam logic [3:0] OPC_ADD  = 4'd4;
  localparam logic [3:0] OPC_AND  = 4'd5;
  localparam logic [3:0] OPC_OR   = 4'd6;
  localparam logic [3:0] OPC_XOR  = 4'd7;
  localparam logic [3:0] OPC_MOD  = 4'd8;
  localparam logic [3:0] OPC_LDX  = 4'd9;
  localparam logic [3:0] OPC_LDY  = 4'd10;

  // Condition selects
  localparam logic [3:0] COND_ALWAYS = 4'h0;
  localparam logic [3:0] COND_ZERO   = 4'h5;
  localparam logic [3:0] COND_NEG    = 4'h7;

  // Modify sub-codes
  localparam logic [2:0] MOD_SHR = 3'd2;
  localparam logic [2:0] MOD_SHL = 3'd3;
  localparam logic [2:0] MOD_NEG = 3'd6;
  localparam logic [2:0] MOD_ABS = 3'd7;

  typedef enum logic [3:0] {
    FN_NONE, FN_LOAD, FN_SUB, FN_CMP, FN_ADD, FN_AND, FN_OR, FN_XOR,
    FN_SHR, FN_SHL, FN_NEG, FN_ABS, FN_LDX, FN_LDY
  } aluFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    aluFn_e fn;
    logic   useShort;
    logic   wrAcc;
    logic   wrArith;   // update all four flags from the 16-bit result
    logic   wrZn;      // update Z and N from the 32-bit accumulator
    logic   wrX;
    logic   wrY;
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       shortSel,
  input  logic [3:0] condSel,
  input  logic       condPol,
  input  logic [2:0] modCode,
  input  logic       flagZ,
  input  logic       flagN,
  output aluStrobe_t strobe,
  output logic       condTrue
);

  aluFn_e fnSel;

  always_comb begin
    unique case (condSel)
      COND_ALWAYS: condTrue = 1'b1;
      COND_ZERO:   condTrue = (flagZ == condPol);
      COND_NEG:    condTrue = (flagN == condPol);
      default:     condTrue = 1'b0;
    endcase
  end

  always_comb begin
    fnSel = FN_NONE;
    if (opValid) begin
      unique case (opCode)
        OPC_LOAD: fnSel = FN_LOAD;
        OPC_SUB:  fnSel = FN_SUB;
        OPC_CMP:  fnSel = FN_CMP;
        OPC_ADD:  fnSel = FN_ADD;
        OPC_AND:  fnSel = FN_AND;
        OPC_OR:   fnSel = FN_OR;
        OPC_XOR:  fnSel = FN_XOR;
        OPC_LDX:  fnSel = FN_LDX;
        OPC_LDY:  fnSel = FN_LDY;
        OPC_MOD: begin
          if (condTrue) begin
            unique case (modCode)
              MOD_SHR: fnSel = FN_SHR;
              MOD_SHL: fnSel = FN_SHL;
              MOD_NEG: fnSel = FN_NEG;
              MOD_ABS: fnSel = FN_ABS;
              default: fnSel = FN_NONE;
            endcase
          end
        end
        default: fnSel = FN_NONE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.fn       = fnSel;
    strobe.useShort = shortSel;
    unique case (fnSel)
      FN_LOAD, FN_AND, FN_OR, FN_XOR, FN_SHR, FN_SHL, FN_NEG, FN_ABS: begin
        strobe.wrAcc = 1'b1;
        strobe.wrZn  = 1'b1;
      end
      FN_ADD, FN_SUB: begin
        strobe.wrAcc   = 1'b1;
        strobe.wrArith = 1'b1;
      end
      FN_CMP:  strobe.wrArith = 1'b1;
      FN_LDX:  strobe.wrX     = 1'b1;
      FN_LDY:  strobe.wrY     = 1'b1;
      default: ;
    endcase
  end

  // R9: a modify function only reaches the datapath while the condition holds
  a_r9_mod_gated: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fn inside {FN_SHR, FN_SHL, FN_NEG, FN_ABS}) |-> (condTrue && opValid && opCode == OPC_MOD));

  // R11: nothing is strobed without a valid operation
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !(strobe.wrAcc || strobe.wrArith || strobe.wrZn || strobe.wrX || strobe.wrY));

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  aluStrobe_t            strobe,
  input  logic [DATA_W-1:0]     operand,
  input  logic [IMM_W-1:0]      immByte,
  output logic [2*DATA_W-1:0]   acc,
  output logic [2*DATA_W-1:0]   product,
  output logic [DATA_W-1:0]     status,
  output logic                  flagZ,
  output logic                  flagN
);

  localparam int ACC_W = 2 * DATA_W;
  localparam int MSB   = DATA_W - 1;
  localparam int AMSB  = ACC_W - 1;

  logic [ACC_W-1:0]  accQ, accNext;
  logic [DATA_W-1:0] xQ, yQ;
  logic              flagL, flagV;
  logic [DATA_W-1:0] hi, opVal, arithRes;
  logic [DATA_W:0]   sumAdd, sumSub;
  logic              carryNext, ovfNext;
  logic [ACC_W-1:0]  xWide, yWide, mulRaw;

  assign hi    = accQ[AMSB:DATA_W];
  assign opVal = strobe.useShort ? {{(DATA_W-IMM_W){1'b0}}, immByte} : operand;

  assign sumAdd = {1'b0, hi} + {1'b0, opVal};
  assign sumSub = {1'b0, hi} - {1'b0, opVal};

  always_comb begin
    if (strobe.fn == FN_ADD) begin
      arithRes  = sumAdd[MSB:0];
      carryNext = sumAdd[DATA_W];
      ovfNext   = (hi[MSB] == opVal[MSB]) && (arithRes[MSB] != hi[MSB]);
    end else begin
      arithRes  = sumSub[MSB:0];
      carryNext = sumSub[DATA_W];
      ovfNext   = (hi[MSB] != opVal[MSB]) && (arithRes[MSB] != hi[MSB]);
    end
  end

  always_comb begin
    unique case (strobe.fn)
      FN_LOAD: accNext = {opVal, accQ[MSB:0]};
      FN_ADD,
      FN_SUB:  accNext = {arithRes, accQ[MSB:0]};
      FN_AND:  accNext = accQ & {opVal, {DATA_W{1'b0}}};
      FN_OR:   accNext = accQ | {opVal, {DATA_W{1'b0}}};
      FN_XOR:  accNext = accQ ^ {opVal, {DATA_W{1'b0}}};
      FN_SHR:  accNext = {accQ[AMSB], accQ[AMSB:1]};
      FN_SHL:  accNext = {accQ[AMSB-1:0], 1'b0};
      FN_NEG:  accNext = ~accQ + 1'b1;
      FN_ABS:  accNext = accQ[AMSB] ? (~accQ + 1'b1) : accQ;
      default: accNext = accQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      xQ    <= '0;
      yQ    <= '0;
      flagL <= 1'b0;
      flagZ <= 1'b0;
      flagV <= 1'b0;
      flagN <= 1'b0;
    end else begin
      if (strobe.wrAcc) accQ <= accNext;
      if (strobe.wrX)   xQ   <= opVal;
      if (strobe.wrY)   yQ   <= opVal;
      if (strobe.wrArith) begin
        flagL <= carryNext;
        flagV <= ovfNext;
        flagZ <= (arithRes == '0);
        flagN <= arithRes[MSB];
      end else if (strobe.wrZn) begin
        flagZ <= (accNext == '0);
        flagN <= accNext[AMSB];
      end
    end
  end

  // Fractional multiply: sign-extend both factors, multiply, double
  assign xWide   = {{DATA_W{xQ[MSB]}}, xQ};
  assign yWide   = {{DATA_W{yQ[MSB]}}, yQ};
  assign mulRaw  = xWide * yWide;
  assign product = {mulRaw[AMSB-1:0], 1'b0};

  assign acc    = accQ;
  assign status = {flagN, flagV, flagZ, flagL, {(DATA_W-4){1'b0}}};

  // R4: compare leaves the accumulator untouched
  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fn == FN_CMP |=> $stable(accQ));

  // R5: AND with the shifted operand empties the low half
  a_r5_and_clears_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fn == FN_AND |=> accQ[MSB:0] == '0);

  // R2/R5/R8: Z and N follow the full accumulator after whole-word updates
  a_r8_zn_track: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrZn |=> (flagZ == (accQ == '0)) && (flagN == accQ[AMSB]));

  // R11: no strobe, no state change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fn == FN_NONE |=> $stable(accQ) && $stable(status) && $stable(product));

  // R8: absolute value never produces a negative result except the most negative input
  a_r8_abs_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fn == FN_ABS && accQ != {1'b1, {(ACC_W-1){1'b0}}}) |=> !accQ[AMSB]);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   operand,
  input  logic                shortSel,
  input  logic [IMM_W-1:0]    immByte,
  input  logic [3:0]          condSel,
  input  logic                condPol,
  input  logic [2:0]          modCode,
  output logic [2*DATA_W-1:0] acc,
  output logic [2*DATA_W-1:0] product,
  output logic [DATA_W-1:0]   status,
  output logic                condTrue
);

  aluStrobe_t strobe;
  logic       flagZ, flagN;

  acc_alu_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .shortSel (shortSel),
    .condSel  (condSel),
    .condPol  (condPol),
    .modCode  (modCode),
    .flagZ    (flagZ),
    .flagN    (flagN),
    .strobe   (strobe),
    .condTrue (condTrue)
  );

  acc_alu_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (operand),
    .immByte (immByte),
    .acc     (acc),
    .product (product),
    .status  (status),
    .flagZ   (flagZ),
    .flagN   (flagN)
  );

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [15:0] operand = '0;
  logic        shortSel = 1'b0;
  logic [7:0]  immByte = '0;
  logic [3:0]  condSel = '0;
  logic        condPol = 1'b0;
  logic [2:0]  modCode = '0;
  logic [31:0] acc, product;
  logic [15:0] status;
  logic        condTrue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] mAcc = '0;
  logic [15:0] mX = '0, mY = '0;
  bit mL = 0, mZ = 0, mV = 0, mN = 0;

  always #2 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .operand(operand),
    .shortSel(shortSel), .immByte(immByte), .condSel(condSel), .condPol(condPol),
    .modCode(modCode), .acc(acc), .product(product), .status(status), .condTrue(condTrue)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit modelCond(logic [3:0] sel, bit pol);
    if (sel == 4'h0) return 1;
    if (sel == 4'h5) return mZ == pol;
    if (sel == 4'h7) return mN == pol;
    return 0;
  endfunction

  function automatic logic [31:0] modelProd();
    longint p;
    p = longint'($signed(mX)) * longint'($signed(mY)) * 2;
    return p[31:0];
  endfunction

  task automatic compareAll(string req);
    check(req, "acc", acc, mAcc);
    check("R10", "product", product, modelProd());
    check("R12", "status", status, {mN, mV, mZ, mL, 12'h000});
  endtask

  task automatic modelArith(bit isAdd, bit keep, int unsigned opv);
    int unsigned h, r;
    int sh, so, sr;
    h  = mAcc[31:16];
    sh = int'($signed(16'(h)));
    so = int'($signed(16'(opv)));
    if (isAdd) begin
      r  = (h + opv) & 32'hffff;
      mL = (h + opv) > 32'hffff;
      sr = sh + so;
    end else begin
      r  = (h - opv) & 32'hffff;
      mL = h < opv;
      sr = sh - so;
    end
    mV = (sr > 32767) || (sr < -32768);
    mZ = (r == 0);
    mN = r[15];
    if (!keep) mAcc[31:16] = r[15:0];
  endtask

  // apply one operation, check condTrue, then check registered results
  task automatic step(logic [3:0] opc, logic [15:0] opnd, bit sh, logic [7:0] imm,
                      logic [3:0] cs, bit cp, logic [2:0] mc, bit vld, string req);
    int unsigned opv;
    bit c;
    @(negedge clk);
    opValid = vld; opCode = opc; operand = opnd; shortSel = sh; immByte = imm;
    condSel = cs; condPol = cp; modCode = mc;
    #1;
    c = modelCond(cs, cp);
    check("R7", "condTrue", condTrue, c);
    opv = sh ? {24'h0, imm} : {16'h0, opnd};
    if (vld) begin
      case (opc)
        4'd1: begin mAcc[31:16] = opv[15:0]; mZ = (mAcc == 0); mN = mAcc[31]; end
        4'd2: modelArith(0, 0, opv);
        4'd3: modelArith(0, 1, opv);
        4'd4: modelArith(1, 0, opv);
        4'd5, 4'd6, 4'd7: begin
          if (opc == 4'd5) mAcc = mAcc & {opv[15:0], 16'h0};
          else if (opc == 4'd6) mAcc = mAcc | {opv[15:0], 16'h0};
          else mAcc = mAcc ^ {opv[15:0], 16'h0};
          mZ = (mAcc == 0); mN = mAcc[31];
        end
        4'd8: if (c && (mc == 2 || mc == 3 || mc == 6 || mc == 7)) begin
          if (mc == 2) mAcc = $signed(mAcc) >>> 1;
          else if (mc == 3) mAcc = mAcc << 1;
          else if (mc == 6) mAcc = 32'(0 - mAcc);
          else if (mAcc[31]) mAcc = 32'(0 - mAcc);
          mZ = (mAcc == 0); mN = mAcc[31];
        end
        4'd9:  mX = opv[15:0];
        4'd10: mY = opv[15:0];
        default: ;
      endcase
    end
    @(negedge clk);
    opValid = 1'b0;
    compareAll(req);
  endtask

  function automatic string reqOf(logic [3:0] opc);
    case (opc)
      4'd1: return "R2";
      4'd2, 4'd4: return "R3";
      4'd3: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R8";
      4'd9, 4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] pickVal();
    case ($urandom_range(0, 5))
      0: return 16'h0000;
      1: return 16'h7fff;
      2: return 16'h8000;
      3: return 16'hffff;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compareAll("R1");
    check("R1", "acc at reset", acc, 0);
    check("R1", "status at reset", status, 0);
    rstN = 1'b1;
    // R2 load, low half kept
    step(4'd1, 16'h8001, 0, 0, 0, 0, 0, 1, "R2");
    // R5 OR sets upper, XOR, AND clears low
    step(4'd6, 16'h0f00, 0, 0, 0, 0, 0, 1, "R5");
    step(4'd1, 16'h0000, 0, 0, 0, 0, 0, 1, "R2");
    // R3 overflow at 0x7fff+1
    step(4'd1, 16'h7fff, 0, 0, 0, 0, 0, 1, "R2");
    step(4'd4, 16'h0001, 0, 0, 0, 0, 0, 1, "R3");
    // R3 borrow from zero
    step(4'd1, 16'h0000, 0, 0, 0, 0, 0, 1, "R2");
    step(4'd2, 16'h0001, 0, 0, 0, 0, 0, 1, "R3");
    // R3 carry out 0xffff+1 gives zero
    step(4'd4, 16'h0001, 0, 0, 0, 0, 0, 1, "R3");
    // R4 compare equal: Z set, acc unchanged
    step(4'd1, 16'h1234, 0, 0, 0, 0, 0, 1, "R2");
    step(4'd3, 16'h1234, 0, 0, 0, 0, 0, 1, "R4");
    // R6 short immediate zero-extended (operand ignored)
    step(4'd4, 16'hffff, 1, 8'hff, 0, 0, 0, 1, "R6");
    // R5 low-half behaviour: shift a value into the low half first
    step(4'd8, 0, 0, 0, 0, 0, 3'd2, 1, "R8");
    step(4'd7, 16'hffff, 0, 0, 0, 0, 0, 1, "R5");
    step(4'd5, 16'hffff, 0, 0, 0, 0, 0, 1, "R5");
    // R8 abs of most negative
    step(4'd1, 16'h8000, 0, 0, 0, 0, 0, 1, "R2");
    step(4'd5, 16'h8000, 0, 0, 0, 0, 0, 1, "R5");
    step(4'd8, 0, 0, 0, 0, 0, 3'd7, 1, "R8");
    step(4'd8, 0, 0, 0, 0, 0, 3'd2, 1, "R8");
    step(4'd8, 0, 0, 0, 0, 0, 3'd6, 1, "R8");
    step(4'd8, 0, 0, 0, 0, 0, 3'd3, 1, "R8");
    // R9 condition false (Z=1 needed, Z=0 now) and unused code
    step(4'd8, 0, 0, 0, 4'h5, 1, 3'd6, 1, "R9");
    step(4'd8, 0, 0, 0, 4'h0, 0, 3'd1, 1, "R9");
    step(4'd8, 0, 0, 0, 4'h3, 0, 3'd6, 1, "R9");
    // R7 N-condition taken
    step(4'd8, 0, 0, 0, 4'h7, 1, 3'd7, 1, "R7");
    // R10 product of -1 * 0x8000
    step(4'd9, 16'hffff, 0, 0, 0, 0, 0, 1, "R10");
    step(4'd10, 16'h8000, 0, 0, 0, 0, 0, 1, "R10");
    step(4'd10, 16'h0000, 1, 8'h03, 0, 0, 0, 1, "R10");
    // R11 invalid op and unused code
    step(4'd4, 16'h1111, 0, 0, 0, 0, 0, 0, "R11");
    step(4'd12, 16'h1111, 0, 0, 0, 0, 0, 1, "R11");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] opc;
      logic [3:0] csArr[4] = '{4'h0, 4'h5, 4'h7, 4'h2};
      opc = 4'($urandom_range(0, 12));
      step(opc, pickVal(), bit'($urandom_range(0, 3) == 0), 8'($urandom),
           csArr[$urandom_range(0, 3)], bit'($urandom_range(0, 1)),
           3'($urandom), bit'($urandom_range(0, 7) != 0), reqOf(opc));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule